// File: doc/BRIEF.md
# UART Receive Byte Queue with Level Interrupt

This block is the receive-side storage of a UART. It holds up to sixteen received bytes in a circular buffer. A read position and an occupancy count track the buffer, and the write slot is derived from the two. The serial receiver offers a byte with a push strobe. The register interface takes the oldest byte with a pop strobe; this strobe is the read of the data register. The byte at the head of the buffer is always visible at the output, so a register read returns it in the same cycle.

A line-control bit selects queue mode. With queue mode off, the block behaves like a single holding register: it accepts a byte only when it is empty. The block keeps an empty flag and a full flag as registered state. A push refused for lack of room is dropped and latches a sticky overrun bit. A raw receive interrupt is set when an accepted push raises the occupancy to the trigger level. It is cleared when a pop lowers the occupancy to one below that level. The trigger level defaults to one, so the interrupt is raised as soon as the buffer holds any byte.

Top module: `uart_rxbuf`

## Requirements
- R1: After reset, rx_empty=1, rx_full=0, rx_irq_raw=0, rx_overrun=0 and push_ready=1.
- R2: Bytes leave in the order they were accepted. pop_data always shows the byte at the read position, combinationally.
- R3: With fifo_mode=1, push_ready is 1 while fewer than 16 bytes are held. After 16 accepted pushes it is 0.
- R4: With fifo_mode=0, push_ready is 1 only while the buffer is empty.
- R5: A push made while push_ready=0 is dropped and leaves the contents unchanged. It sets rx_overrun, which stays 1 until reset.
- R6: An accepted push clears rx_empty. A pop that takes the last byte, with no accepted push in the same cycle, sets rx_empty.
- R7: An accepted push sets rx_full when it brings the occupancy to 16, or when force_full=1. Otherwise any pop clears rx_full.
- R8: A pop of an empty buffer leaves the read position unchanged, and pop_data keeps showing the stale byte at that position. The flags keep their values, except that rx_full is cleared.
- R9: The trigger level is the parameter TRIG_LEVEL, default 1. An accepted push without an effective pop, which brings the occupancy to the trigger level, sets rx_irq_raw. A pop without an accepted push, which brings it to TRIG_LEVEL-1, clears it.
- R10: An accepted push and an effective pop in the same cycle leave the occupancy unchanged. The head advances and the new byte is appended.
- R11: The read and write positions wrap from 15 to 0, and the byte order is kept across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_mode | input | 1 | Line-control queue enable: 1 gives a depth of 16, 0 gives a depth of 1 |
| force_full | input | 1 | Control bit that makes every accepted push set rx_full |
| push_valid | input | 1 | Receiver offers a byte |
| push_data | input | 8 | Received byte |
| push_ready | output | 1 | Buffer can accept a byte this cycle |
| pop_req | input | 1 | Data-register read strobe |
| pop_data | output | 8 | Byte at the read position |
| rx_empty | output | 1 | Receive-empty flag |
| rx_full | output | 1 | Receive-full flag |
| rx_irq_raw | output | 1 | Raw receive interrupt |
| rx_overrun | output | 1 | Sticky indication of a dropped push |

## Verification
A read position that has drifted shows up on the next pop as a wrong pop_data byte, in the same cycle as the read. Because every byte is checked against a reference queue, the error is caught at the first affected read. A wrong occupancy first shows up at push_ready, at the moment the count crosses 0, 1 or 16. It also shows up as a flag or interrupt edge one cycle early or late, since the registered flags change one edge after the push or pop. The random phase switches queue mode while bytes are held and pops at empty and at full. This drives the count boundaries where such errors appear.

// File: rtl/uart_rxbuf_pkg.sv
package uart_rxbuf_pkg;
  localparam int unsigned RXB_DEPTH_DEF = 16;
  localparam int unsigned RXB_WIDTH_DEF = 8;
  localparam int unsigned RXB_TRIG_DEF  = 1;

  typedef struct packed {
    logic push_ok;
    logic push_drop;
    logic pop_eff;
    logic pop_req;
  } rxb_evt_t;
endpackage

// File: rtl/uart_rxbuf_ptr.sv
module uart_rxbuf_ptr #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned PW    = $clog2(DEPTH),
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_mode,
  input  logic          push_valid,
  input  logic          pop_req,
  output logic          ready,
  output logic          push_ok,
  output logic          pop_eff,
  output logic [PW-1:0] rd_idx,
  output logic [PW-1:0] wr_idx,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);
  localparam logic [PW-1:0] IDX_TOP = PW'(DEPTH - 1);

  logic [PW-1:0] rd_nx;
  logic [CW-1:0] cnt_nx;
  logic [CW:0]   slot_sum;

  always_comb begin
    ready    = fifo_mode ? (count < CNT_MAX) : (count == '0);
    push_ok  = push_valid & ready;
    pop_eff  = pop_req & (count != '0);
    slot_sum = {{(CW + 1 - PW){1'b0}}, rd_idx} + {1'b0, count};
    if (slot_sum >= (CW + 1)'(DEPTH)) begin
      slot_sum = slot_sum - (CW + 1)'(DEPTH);
    end
    wr_idx = slot_sum[PW-1:0];
  end

  always_comb begin
    rd_nx  = rd_idx;
    cnt_nx = count;
    if (pop_eff) begin
      rd_nx = (rd_idx == IDX_TOP) ? '0 : rd_idx + 1'b1;
    end
    case ({push_ok, pop_eff})
      2'b10:   cnt_nx = count + 1'b1;
      2'b01:   cnt_nx = count - 1'b1;
      default: cnt_nx = count;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_idx <= '0;
      count  <= '0;
    end else begin
      if (pop_eff) rd_idx <= rd_nx;
      if (push_ok ^ pop_eff) count <= cnt_nx;
    end
  end

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_MAX);
  assert_single_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_mode && push_ok) |-> (count == '0));
  assert_hold_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_eff) |=> (count == $past(count)));
  assert_rd_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_eff && rd_idx == IDX_TOP) |=> (rd_idx == '0));
endmodule

// File: rtl/uart_rxbuf_mem.sv
module uart_rxbuf_mem #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 8,
  parameter int unsigned PW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [PW-1:0]    wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [PW-1:0]    rd_idx,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] slot_q [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    logic slot_en;
    assign slot_en = we && (wr_idx == PW'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[gi] <= '0;
      end else if (slot_en) begin
        slot_q[gi] <= wr_data;
      end
    end
  end

  assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/uart_rxbuf_flags.sv
module uart_rxbuf_flags
  import uart_rxbuf_pkg::*;
#(
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned TRIG_LEVEL = 1,
  parameter int unsigned CW         = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  rxb_evt_t      evt,
  input  logic          force_full,
  input  logic [CW-1:0] count,
  output logic          empty,
  output logic          full,
  output logic          irq_raw,
  output logic          overrun
);
  localparam logic [CW-1:0] CNT_MAX  = CW'(DEPTH);
  localparam logic [CW-1:0] TRIG     = CW'(TRIG_LEVEL);
  localparam logic [CW-1:0] TRIG_LOW = CW'(TRIG_LEVEL - 1);

  logic          empty_nx, full_nx, irq_nx, ovr_nx;
  logic [CW-1:0] cnt_after;
  logic          push_only, pop_only;

  always_comb begin
    push_only = evt.push_ok & ~evt.pop_eff;
    pop_only  = evt.pop_req & ~evt.push_ok;
    cnt_after = count;
    if (push_only)                         cnt_after = count + 1'b1;
    else if (evt.pop_eff && !evt.push_ok)  cnt_after = count - 1'b1;

    empty_nx = empty;
    if (evt.push_ok)                                        empty_nx = 1'b0;
    else if (evt.pop_eff && count == CW'(1))                empty_nx = 1'b1;

    full_nx = full;
    if (evt.push_ok && (force_full || cnt_after == CNT_MAX)) full_nx = 1'b1;
    else if (evt.pop_req)                                   full_nx = 1'b0;

    irq_nx = irq_raw;
    if (push_only && cnt_after == TRIG)                     irq_nx = 1'b1;
    else if (pop_only && cnt_after == TRIG_LOW)             irq_nx = 1'b0;

    ovr_nx = overrun | evt.push_drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty   <= 1'b1;
      full    <= 1'b0;
      irq_raw <= 1'b0;
      overrun <= 1'b0;
    end else begin
      empty   <= empty_nx;
      full    <= full_nx;
      irq_raw <= irq_nx;
      overrun <= ovr_nx;
    end
  end

  assert_ovr_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  assert_force_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.push_ok && force_full) |=> full);
  assert_irq_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.push_ok && !evt.pop_eff && count == TRIG - 1'b1) |=> irq_raw);
  assert_irq_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.pop_eff && !evt.push_ok && count == TRIG) |=> !irq_raw);
endmodule

// File: rtl/uart_rxbuf.sv
module uart_rxbuf
  import uart_rxbuf_pkg::*;
#(
  parameter int unsigned DEPTH      = RXB_DEPTH_DEF,
  parameter int unsigned WIDTH      = RXB_WIDTH_DEF,
  parameter int unsigned TRIG_LEVEL = RXB_TRIG_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_mode,
  input  logic             force_full,
  input  logic             push_valid,
  input  logic [WIDTH-1:0] push_data,
  output logic             push_ready,
  input  logic             pop_req,
  output logic [WIDTH-1:0] pop_data,
  output logic             rx_empty,
  output logic             rx_full,
  output logic             rx_irq_raw,
  output logic             rx_overrun
);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic          ready_w, push_ok_w, pop_eff_w;
  logic [PW-1:0] rd_idx_w, wr_idx_w;
  logic [CW-1:0] count_w;
  rxb_evt_t      evt_w;

  uart_rxbuf_ptr #(.DEPTH(DEPTH), .PW(PW), .CW(CW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode),
    .push_valid(push_valid), .pop_req(pop_req),
    .ready(ready_w), .push_ok(push_ok_w), .pop_eff(pop_eff_w),
    .rd_idx(rd_idx_w), .wr_idx(wr_idx_w), .count(count_w)
  );

  uart_rxbuf_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PW(PW)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(push_ok_w), .wr_idx(wr_idx_w),
    .wr_data(push_data), .rd_idx(rd_idx_w), .rd_data(pop_data)
  );

  always_comb begin
    evt_w.push_ok   = push_ok_w;
    evt_w.push_drop = push_valid & ~ready_w;
    evt_w.pop_eff   = pop_eff_w;
    evt_w.pop_req   = pop_req;
  end

  uart_rxbuf_flags #(.DEPTH(DEPTH), .TRIG_LEVEL(TRIG_LEVEL), .CW(CW)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt(evt_w), .force_full(force_full),
    .count(count_w), .empty(rx_empty), .full(rx_full),
    .irq_raw(rx_irq_raw), .overrun(rx_overrun)
  );

  assign push_ready = ready_w;

  assert_empty_track_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_empty == (count_w == '0));
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (count_w == CW'(DEPTH)) |-> !push_ready);
  assert_empty_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && rx_empty && !push_valid) |=> $stable(pop_data));
endmodule

// File: tb/uart_rxbuf_tb.sv
`timescale 1ns/1ps
module uart_rxbuf_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic fifo_mode, force_full, push_valid, pop_req;
  logic [7:0] push_data;
  logic push_ready, rx_empty, rx_full, rx_irq_raw, rx_overrun;
  logic [7:0] pop_data;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] m_mem [16];
  int m_rd, m_cnt;
  logic m_empty, m_full, m_irq, m_ovr;

  always #2.5 clk = ~clk;

  uart_rxbuf u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .force_full(force_full),
    .push_valid(push_valid), .push_data(push_data), .push_ready(push_ready),
    .pop_req(pop_req), .pop_data(pop_data), .rx_empty(rx_empty),
    .rx_full(rx_full), .rx_irq_raw(rx_irq_raw), .rx_overrun(rx_overrun)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic m_ready(input logic fm);
    return fm ? (m_cnt < 16) : (m_cnt == 0);
  endfunction

  task automatic step(input logic pv, input logic [7:0] pd, input logic pp,
                      input logic fm, input logic ff);
    logic rdy, pok, peff;
    int after;
    @(negedge clk);
    push_valid = pv; push_data = pd; pop_req = pp; fifo_mode = fm; force_full = ff;
    #1;
    rdy = m_ready(fm);
    chk(fm ? "R3 ready" : "R4 ready", push_ready, rdy);
    chk("R2 head", pop_data, m_mem[m_rd]);
    pok  = pv && rdy;
    peff = pp && (m_cnt != 0);
    after = m_cnt + (pok ? 1 : 0) - (peff ? 1 : 0);
    if (pok) m_mem[(m_rd + m_cnt) % 16] = pd;
    if (pok) m_empty = 1'b0;
    else if (peff && m_cnt == 1) m_empty = 1'b1;
    if (pok && (ff || after == 16)) m_full = 1'b1;
    else if (pp) m_full = 1'b0;
    if (pok && !peff && after == 1) m_irq = 1'b1;
    else if (pp && !pok && after == 0) m_irq = 1'b0;
    if (pv && !rdy) m_ovr = 1'b1;
    if (peff) m_rd = (m_rd + 1) % 16;
    m_cnt = after;
    @(posedge clk);
    #1;
    chk("R6 empty", rx_empty, m_empty);
    chk("R7 full", rx_full, m_full);
    chk("R9 irq", rx_irq_raw, m_irq);
    chk("R5 overrun", rx_overrun, m_ovr);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234abcd));
    rst_n = 1'b0; fifo_mode = 1'b1; force_full = 1'b0;
    push_valid = 1'b0; pop_req = 1'b0; push_data = '0;
    for (int i = 0; i < 16; i++) m_mem[i] = '0;
    m_rd = 0; m_cnt = 0; m_empty = 1; m_full = 0; m_irq = 0; m_ovr = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 empty", rx_empty, 1); chk("R1 full", rx_full, 0);
    chk("R1 irq", rx_irq_raw, 0); chk("R1 ovr", rx_overrun, 0);
    chk("R1 ready", push_ready, 1);
    @(negedge clk); rst_n = 1'b1;

    // R8: pops of an empty buffer
    step(0, 8'h00, 1, 1, 0);
    step(0, 8'h00, 1, 1, 0);
    // R3/R11: fill to 16, then one extra push is dropped (R5)
    for (int i = 0; i < 16; i++) step(1, 8'h40 + 8'(i), 0, 1, 0);
    chk("R3 full at 16", rx_full, 1);
    step(1, 8'hEE, 0, 1, 0);
    chk("R5 sticky", rx_overrun, 1);
    // R10 at full: simultaneous push is refused, pop proceeds
    step(1, 8'h99, 1, 1, 0);
    for (int i = 0; i < 20; i++) step(0, 8'h00, 1, 1, 0);
    // R4: single-entry mode
    step(1, 8'hA1, 0, 0, 0);
    step(1, 8'hA2, 0, 0, 0);
    step(0, 8'h00, 1, 0, 0);
    // R7: force_full
    step(1, 8'hB3, 0, 1, 1);
    step(1, 8'hB4, 1, 1, 0);
    step(0, 8'h00, 1, 1, 0);
    // R11 wrap with R10 overlap
    for (int i = 0; i < 40; i++) step(1, 8'(i), (i > 2), 1, 0);
    for (int i = 0; i < 5; i++) step(0, 8'h00, 1, 1, 0);

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[2:0] < 3'd5, r[15:8], r[18:16] < 3'd3, r[23:20] != 4'd0, r[27:24] == 4'd0);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule